// File: doc/BRIEF.md
# Serially Programmed Clock-Pair Enable Controller

This block is the control side of a clock fan-out buffer. A two-wire serial master programs two 8-bit enable registers using a block-write transfer. The transfer carries, in order, the device address, a command byte, a byte count, six placeholder bytes and then the two enable bytes. The register bits open or close six differential clock pairs and one single-ended feedback clock. All of these are built from a single reference clock.

The serial lines are brought into the system clock domain through a short synchronizer. START and STOP are recognised from data-line edges while the serial clock is high. The block acknowledges by pulling the data line low through an open-drain enable output. A change of enable reaches the clock outputs only while the reference clock is low, so no pulse that has already begun is cut short. Both registers can be read back at the ports for test.

Top module: `clkgate_blkwr_ctrl`

## Requirements
- R1: After reset, register A reads 0x1F and register B reads 0xFF. All six pair enables and the feedback enable are 1, and the data-line pull-down is released.
- R2: The first byte after START is acknowledged only when its bits 7:1, sent MSB first, equal the parameter `DEV_ADDR` and its bit 0 is 0 (write). Any other first byte receives no acknowledge on it or on any later byte of that transfer, and both registers stay unchanged. The pull-down is only ever asserted during an acknowledge slot.
- R3: In an addressed write, the command byte and the count byte are acknowledged and then six placeholder data bytes are acknowledged and discarded. The seventh data byte is stored whole in register A and the eighth in register B, and both read back all 8 bits, reserved ones included.
- R4: Pair enables 5, 4 and 3 follow register A bits 2, 1 and 0. The feedback enable follows register A bit 4. Pair enables 2, 1 and 0 follow register B bits 4, 2 and 0. A value of 1 enables. The other bits drive no output.
- R5: Data bytes after the eighth are acknowledged and do not change either register.
- R6: A STOP or a repeated START ends the transfer, and register bytes already received keep their new values. A repeated START opens a new transfer that is acknowledged normally.
- R7: Each true output equals the reference clock ANDed with its applied enable. Each complement output is the inverse of its true output, so it is held high when the pair is disabled. The feedback output equals the reference clock ANDed with the applied feedback enable.
- R8: An enable change is applied to the outputs only on system clock edges where the reference clock is low. While the reference clock is held high, a register write changes no clock output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls the data line low when 1 (acknowledge) |
| ref_clk | input | 1 | Reference clock to be distributed |
| pair_en | output | 6 | Programmed enable of each differential pair |
| fb_en | output | 1 | Programmed enable of the feedback clock |
| reg_a_q | output | 8 | Readback of register A |
| reg_b_q | output | 8 | Readback of register B |
| clk_t | output | 6 | True clock outputs |
| clk_c | output | 6 | Complement clock outputs |
| clk_fb | output | 1 | Single-ended feedback clock |

## Verification
The bench sends only correct sequences on the serial lines. A wrong byte position or bit counter shows up as a missing or misplaced acknowledge on the data line within the same byte. It also shows up as the wrong data byte landing in the readback registers once the transfer ends. A wrong enable mapping or a broken gating register is visible at the true, complement and feedback outputs within one reference period after the write. A gating update taken while the reference clock is high is caught by freezing the reference clock high and watching a pair that the write has just disabled.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // address, command and count precede the data bytes
  localparam int HDR_BYTES = 3;
  localparam int N_PAIRS   = 6;
  localparam int FB_BIT    = 4;
  localparam logic [7:0] RST_A = 8'h1F;
  localparam logic [7:0] RST_B = 8'hFF;

  // pair enables, index 5 down to 0
  function automatic logic [N_PAIRS-1:0] pair_map(input logic [7:0] a, input logic [7:0] b);
    return {a[2], a[1], a[0], b[4], b[2], b[0]};
  endfunction
endpackage

// File: rtl/cg_line_sync.sv
module cg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // data edges while the clock line stays high
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/cg_blkwr_slave.sv
module cg_blkwr_slave
  import cg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         N_DUMMY  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       sda_oe,
  output logic [7:0] reg_a,
  output logic [7:0] reg_b
);
  localparam int IDX_REGA = HDR_BYTES + N_DUMMY;
  localparam int IDX_REGB = IDX_REGA + 1;
  localparam int IDX_MAX  = IDX_REGB + 1;
  localparam int IW       = $clog2(IDX_MAX + 1);

  logic          active, in_ack;
  logic [3:0]    bit_cnt;
  logic [7:0]    sh;
  logic [IW-1:0] byte_idx;
  logic          addr_ok;

  assign addr_ok = (sh[7:1] == DEV_ADDR) && !sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      in_ack   <= 1'b0;
      bit_cnt  <= '0;
      sh       <= '0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
      reg_a    <= RST_A;
      reg_b    <= RST_B;
    end else if (start_det) begin
      active   <= 1'b1;
      in_ack   <= 1'b0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      sda_oe   <= 1'b0;
    end else if (stop_det) begin
      active <= 1'b0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (scl_rise && bit_cnt < 4'd8) begin
        sh      <= {sh[6:0], sda_lvl};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall && bit_cnt == 4'd8 && !in_ack) begin
        if (byte_idx == '0 && !addr_ok) begin
          active <= 1'b0;
        end else begin
          sda_oe <= 1'b1;
          in_ack <= 1'b1;
        end
        if (byte_idx == IW'(IDX_REGA)) reg_a <= sh;
        if (byte_idx == IW'(IDX_REGB)) reg_b <= sh;
      end else if (scl_fall && in_ack) begin
        sda_oe  <= 1'b0;
        in_ack  <= 1'b0;
        bit_cnt <= '0;
        if (byte_idx != IW'(IDX_MAX)) byte_idx <= byte_idx + 1'b1;
      end
    end
  end

  a_r2_pulldown_needs_transfer: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> active);
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && !active));
  a_r3_rega_slot: assert property (@(posedge clk) disable iff (rst)
    (reg_a != $past(reg_a)) |-> ($past(byte_idx) == IW'(IDX_REGA)));
  a_r3_regb_slot: assert property (@(posedge clk) disable iff (rst)
    (reg_b != $past(reg_b)) |-> ($past(byte_idx) == IW'(IDX_REGB)));
  a_r5_frozen_past_end: assert property (@(posedge clk) disable iff (rst)
    (active && byte_idx == IW'(IDX_MAX)) |=> ($stable(reg_a) && $stable(reg_b)));
endmodule

// File: rtl/cg_out_gate.sv
module cg_out_gate #(
  parameter int W  = 7,
  parameter int NC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_clk,
  input  logic [W-1:0]  en_req,
  output logic [W-1:0]  out_t,
  output logic [NC-1:0] out_c
);
  logic [W-1:0] en_live;

  // new enables are taken only in the low phase of the reference
  always_ff @(posedge clk) begin
    if (rst)           en_live <= '1;
    else if (!ref_clk) en_live <= en_req;
  end

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign out_t[i] = ref_clk & en_live[i];
    if (i < NC) begin : g_comp
      assign out_c[i] = ~(ref_clk & en_live[i]);
    end
  end

  a_r8_hold_high: assert property (@(posedge clk) disable iff (rst)
    $past(ref_clk) |-> $stable(en_live));
endmodule

// File: rtl/clkgate_blkwr_ctrl.sv
module clkgate_blkwr_ctrl
  import cg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         N_DUMMY     = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic               ref_clk,
  output logic [N_PAIRS-1:0] pair_en,
  output logic               fb_en,
  output logic [7:0]         reg_a_q,
  output logic [7:0]         reg_b_q,
  output logic [N_PAIRS-1:0] clk_t,
  output logic [N_PAIRS-1:0] clk_c,
  output logic               clk_fb
);
  localparam int NLANE = N_PAIRS + 1;

  logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [NLANE-1:0] gt_t;

  cg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cg_blkwr_slave #(.DEV_ADDR(DEV_ADDR), .N_DUMMY(N_DUMMY)) u_slave (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .reg_a(reg_a_q), .reg_b(reg_b_q)
  );

  assign pair_en = pair_map(reg_a_q, reg_b_q);
  assign fb_en   = reg_a_q[FB_BIT];

  cg_out_gate #(.W(NLANE), .NC(N_PAIRS)) u_gate (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .en_req({fb_en, pair_en}),
    .out_t(gt_t), .out_c(clk_c)
  );

  assign clk_t  = gt_t[N_PAIRS-1:0];
  assign clk_fb = gt_t[N_PAIRS];
endmodule

// File: tb/clkgate_blkwr_ctrl_test.sv
module clkgate_blkwr_ctrl_test;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int Q = 5;

  logic clk = 0, rst = 1, scl_m = 1, sda_m = 1, ref_clk = 0;
  bit   ref_run = 1;
  logic sda_oe, fb_en, clk_fb;
  logic [5:0] pair_en, clk_t, clk_c;
  logic [7:0] reg_a_q, reg_b_q;
  wire  sda_bus = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  logic [7:0] pay [0:15];

  clkgate_blkwr_ctrl #(.DEV_ADDR(ADDR)) uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .ref_clk(ref_clk), .pair_en(pair_en), .fb_en(fb_en), .reg_a_q(reg_a_q),
    .reg_b_q(reg_b_q), .clk_t(clk_t), .clk_c(clk_c), .clk_fb(clk_fb)
  );

  always #2.5 clk = ~clk;
  initial begin
    #1;
    forever begin
      #30;
      if (ref_run) ref_clk = ~ref_clk;
    end
  end

  function automatic logic [5:0] exp_pairs(input logic [7:0] a, input logic [7:0] b);
    exp_pairs[5] = a[2]; exp_pairs[4] = a[1]; exp_pairs[3] = a[0];
    exp_pairs[2] = b[4]; exp_pairs[1] = b[2]; exp_pairs[0] = b[0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q();
  endtask

  task automatic i2c_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; q();
    acked = (sda_bus == 1'b0);
    q(); scl_m = 0; q();
  endtask

  // START, address, command, count and n data bytes; no STOP
  task automatic frame(input logic [7:0] abyte, input int n, output int acks, output bit a_ok);
    bit k;
    i2c_start();
    i2c_byte(abyte, a_ok);
    acks = 0;
    i2c_byte(8'h00, k); acks += int'(k);
    i2c_byte(8'h08, k); acks += int'(k);
    for (int i = 0; i < n; i++) begin
      i2c_byte(pay[i], k);
      acks += int'(k);
    end
  endtask

  task automatic chk_outputs(input logic [7:0] a, input logic [7:0] b);
    wait (ref_clk == 1'b1);
    @(negedge clk);
    chk(clk_t == exp_pairs(a, b), "R7 true high phase", clk_t, exp_pairs(a, b));
    chk(clk_c == ~exp_pairs(a, b), "R7 compl high phase", clk_c, ~exp_pairs(a, b));
    chk(clk_fb == a[4], "R7 feedback high phase", clk_fb, a[4]);
    wait (ref_clk == 1'b0);
    @(negedge clk);
    chk(clk_t == 6'h00 && clk_fb == 1'b0, "R7 true low phase", {clk_fb, clk_t}, 7'h00);
    chk(clk_c == 6'h3F, "R7 compl low phase", clk_c, 6'h3F);
  endtask

  task automatic full_write(input logic [7:0] a, input logic [7:0] b);
    int acks; bit aok;
    for (int i = 0; i < 6; i++) pay[i] = 8'(i * 41 + 7);
    pay[6] = a; pay[7] = b;
    frame({ADDR, 1'b0}, 8, acks, aok);
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int acks; bit aok, aok2;
    logic [7:0] a, b, pa, pb;
    repeat (10) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reg_a_q == 8'h1F, "R1 reg A", reg_a_q, 8'h1F);
    chk(reg_b_q == 8'hFF, "R1 reg B", reg_b_q, 8'hFF);
    chk(pair_en == 6'h3F && fb_en, "R1 enables", {fb_en, pair_en}, 7'h7F);
    chk(sda_oe == 1'b0, "R1 pulldown", sda_oe, 0);

    // R3 R4 R7 sweep of register patterns
    for (int k = 0; k < 20; k++) begin
      a = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 37 + 5);
      b = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 91 + 3);
      for (int i = 0; i < 6; i++) pay[i] = 8'(k * 13 + i * 29);
      pay[6] = a; pay[7] = b;
      frame({ADDR, 1'b0}, 8, acks, aok);
      i2c_stop();
      chk(aok, "R2 address ack", aok, 1);
      chk(acks == 10, "R3 byte acks", acks, 10);
      chk(reg_a_q == a, "R3 reg A readback", reg_a_q, a);
      chk(reg_b_q == b, "R3 reg B readback", reg_b_q, b);
      chk(pair_en == exp_pairs(a, b), "R4 pair map", pair_en, exp_pairs(a, b));
      chk(fb_en == a[4], "R4 feedback map", fb_en, a[4]);
      chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
      chk_outputs(a, b);
    end
    pa = reg_a_q; pb = reg_b_q;

    // R2 wrong address and read direction
    for (int i = 0; i < 8; i++) pay[i] = 8'hA5 ^ 8'(i);
    frame({ADDR ^ 7'h01, 1'b0}, 8, acks, aok);
    i2c_stop();
    chk(!aok && acks == 0, "R2 foreign address nack", {aok, 8'(acks)}, 0);
    chk(reg_a_q == pa && reg_b_q == pb, "R2 foreign regs kept", {reg_a_q, reg_b_q}, {pa, pb});
    frame({ADDR, 1'b1}, 8, acks, aok);
    i2c_stop();
    chk(!aok && acks == 0, "R2 read bit nack", {aok, 8'(acks)}, 0);
    chk(reg_a_q == pa && reg_b_q == pb, "R2 read regs kept", {reg_a_q, reg_b_q}, {pa, pb});

    // R5 extra bytes
    for (int i = 0; i < 11; i++) pay[i] = 8'(i * 59 + 17);
    frame({ADDR, 1'b0}, 11, acks, aok);
    i2c_stop();
    chk(acks == 13, "R5 extra acks", acks, 13);
    chk(reg_a_q == pay[6] && reg_b_q == pay[7], "R5 regs from bytes 6,7",
        {reg_a_q, reg_b_q}, {pay[6], pay[7]});
    pb = reg_b_q;

    // R6 stop after register A only
    pay[6] = 8'h5A;
    frame({ADDR, 1'b0}, 7, acks, aok);
    i2c_stop();
    chk(reg_a_q == 8'h5A, "R6 stop keeps A", reg_a_q, 8'h5A);
    chk(reg_b_q == pb, "R6 stop B unchanged", reg_b_q, pb);

    // R6 repeated start after register A
    pay[6] = 8'hC3;
    frame({ADDR, 1'b0}, 7, acks, aok);
    frame({ADDR, 1'b0}, 2, acks, aok2);
    i2c_stop();
    chk(aok2 && acks == 4, "R6 restart acked", {aok2, 8'(acks)}, {1'b1, 8'd4});
    chk(reg_a_q == 8'hC3, "R6 restart keeps A", reg_a_q, 8'hC3);
    chk(reg_b_q == pb, "R6 restart B unchanged", reg_b_q, pb);

    // R8 gating only in low phase
    full_write(8'h1F, 8'hFF);
    wait (ref_clk == 1'b1);
    ref_run = 0;
    full_write(8'h1F, 8'hFE);
    chk(pair_en[0] == 1'b0, "R4 pair0 off", pair_en[0], 0);
    chk(clk_t[0] == 1'b1 && clk_c[0] == 1'b0, "R8 pulse kept while high", {clk_t[0], clk_c[0]}, 2'b10);
    ref_clk = 0;
    repeat (3) @(negedge clk);
    ref_clk = 1;
    repeat (2) @(negedge clk);
    chk(clk_t == 6'h3E && clk_c[0] == 1'b1, "R8 off after low phase", {clk_c[0], clk_t}, {1'b1, 6'h3E});
    full_write(8'h1F, 8'hFF);
    chk(clk_t[0] == 1'b0, "R8 no late start while high", clk_t[0], 0);
    ref_clk = 0;
    repeat (3) @(negedge clk);
    ref_clk = 1;
    repeat (2) @(negedge clk);
    chk(clk_t == 6'h3F && clk_fb == 1'b1, "R8 on after low phase", {clk_fb, clk_t}, 7'h7F);
    ref_run = 1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule